// File: doc/BRIEF.md
# I2S Stereo Audio Serializer

This block turns a pair of parallel signed audio samples, one for the left channel and one for the right, into a standard I2S serial stream. It runs on a fast system clock. An external divider supplies a half-rate serial bit clock and a strobe that is high for one system cycle at the start of each bit-clock period. The block forwards the bit clock, with an optional polarity inversion. It also generates the word-select line and shifts the data out MSB first.

Every frame has 64 bit-clock slots, 32 for each channel, whatever the sample width. A sample narrower than 32 bits sits at the top of its slot and the unused low positions are sent as zeros. Receivers of any width therefore take the bits they can use. Both channels are captured on the same clock edge at the start of the frame.

The block raises a capture marker during the last slot of each frame. An upstream sample source advances one step when the marker and the bit strobe are high together. With a 3.072 MHz bit clock this gives one step per 48 kHz frame, and the new pair is stable before it is captured. An optional resync input moves the frame back to its start.

Top module: `i2s_stereo_serializer`

## Requirements
- R1: While `rstN` is low, and after it is released until the first bit strobe, `sdOut`, `wsOut` and `sampleTaken` are 0. The first strobe after reset starts a new frame.
- R2: A frame spans exactly 64 bit strobes. Cycles without `bitStrobe` do not advance the frame position, however many there are.
- R3: Both `leftIn` and `rightIn` are captured on the first strobe of a frame. Changes to either input later in that frame do not affect the bits sent in that frame.
- R4: Call period k the interval after the k-th strobe of a frame, counting from 0. In periods 0..31 `sdOut` carries the left 32-bit slot, MSB first. In periods 32..63 it carries the right slot, MSB first.
- R5: A sample of `SAMPLE_W` bits occupies the top `SAMPLE_W` positions of its 32-bit slot. The remaining `32-SAMPLE_W` positions are sent as 0.
- R6: `wsOut` is 1 in periods 31..62 and 0 in periods 63 and 0..30. It therefore changes one period before the MSB of each channel.
- R7: `sampleTaken` is 1 only in period 62. It is exactly one bit-clock period wide, and the strobe that ends it comes one slot before the next capture.
- R8: `sdOut` and `wsOut` change only in the cycle after a `bitStrobe`. They stay constant for the rest of each period.
- R9: A strobe with `frameRestart` high makes the next strobe the first strobe of a new frame.
- R10: `sclkOut` equals `bitClkIn` when `INV_BCLK` is 0. It equals the inverse of `bitClkIn` when `INV_BCLK` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClkIn | input | 1 | Serial bit clock, 50/50 duty |
| bitStrobe | input | 1 | One-cycle strobe at the start of each bit-clock period |
| frameRestart | input | 1 | Resync; tie low or pulse at most once per 64 strobes |
| leftIn | input | SAMPLE_W | Left channel sample, two's complement |
| rightIn | input | SAMPLE_W | Right channel sample, two's complement |
| sclkOut | output | 1 | Bit clock to the receiver |
| wsOut | output | 1 | Word select: 0 = left, 1 = right |
| sdOut | output | 1 | Serial data, MSB first |
| sampleTaken | output | 1 | High during the last slot of a frame; advance the upstream source on this AND the bit strobe |

## Verification
The bench builds two instances from the same stimulus. One has `SAMPLE_W=16` and a straight bit clock. The other has `SAMPLE_W=8` with the bit clock inverted and is fed the top byte of each sample. The 16-bit instance brings the full slot layout and the left/right split within reach. The 8-bit instance brings the 24 zero-padded positions and the inverted clock path within reach. A frame paused mid-stream, a mid-frame resync and a mid-frame reset exercise frame alignment on both at once.

// File: rtl/i2s_ser_pkg.sv
`timescale 1ns/1ps
package i2s_ser_pkg;
  localparam int CH_SLOTS    = 32;
  localparam int FRAME_SLOTS = 2 * CH_SLOTS;
  localparam int SLOT_BITS   = $clog2(FRAME_SLOTS);

  typedef struct packed {
    logic loadPair;   // capture both channels, left into shifter
    logic loadRight;  // move held right sample into shifter
    logic shift;      // advance serial data by one bit
  } ctrlStrobe_t;
endpackage

// File: rtl/i2s_ser_ctrl.sv
`timescale 1ns/1ps
module i2s_ser_ctrl
  import i2s_ser_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitStrobe,
  input  logic        frameRestart,
  output ctrlStrobe_t strobes,
  output logic        wsOut,
  output logic        sampleTaken
);
  localparam logic [SLOT_BITS-1:0] FIRST_SLOT = '0;
  localparam logic [SLOT_BITS-1:0] RIGHT_SLOT = SLOT_BITS'(CH_SLOTS);
  localparam logic [SLOT_BITS-1:0] WS_RISE    = SLOT_BITS'(CH_SLOTS - 1);
  localparam logic [SLOT_BITS-1:0] LAST_SLOT  = SLOT_BITS'(FRAME_SLOTS - 1);

  logic [SLOT_BITS-1:0] slotCnt;
  logic                 wsReg;

  always_comb begin
    strobes           = '0;
    strobes.loadPair  = bitStrobe && (slotCnt == FIRST_SLOT);
    strobes.loadRight = bitStrobe && (slotCnt == RIGHT_SLOT);
    strobes.shift     = bitStrobe && (slotCnt != FIRST_SLOT) && (slotCnt != RIGHT_SLOT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
      wsReg   <= 1'b0;
    end else if (bitStrobe) begin
      slotCnt <= frameRestart ? FIRST_SLOT : slotCnt + 1'b1;
      // word select leads each channel's MSB by one period
      wsReg   <= (slotCnt >= WS_RISE) && (slotCnt != LAST_SLOT);
    end
  end

  assign wsOut       = wsReg;
  assign sampleTaken = (slotCnt == LAST_SLOT);

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !frameRestart) |=> (slotCnt == $past(slotCnt) + 1'b1));
  p_slot_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |=> $stable(slotCnt));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && frameRestart) |=> (slotCnt == FIRST_SLOT));
  p_ws_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && slotCnt == WS_RISE) |=> wsOut);
  p_ws_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |=> $stable(wsOut));
  p_taken_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTaken && bitStrobe) |=> !sampleTaken);
endmodule

// File: rtl/i2s_ser_datapath.sv
`timescale 1ns/1ps
module i2s_ser_datapath
  import i2s_ser_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobes,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                sdOut
);
  localparam int PAD_W = CH_SLOTS - SAMPLE_W;

  logic [SAMPLE_W-1:0] rightHold;
  logic [CH_SLOTS-1:0] shiftReg;
  logic [CH_SLOTS-1:0] leftSlot;
  logic [CH_SLOTS-1:0] rightSlot;

  // left-justify a sample in its slot, zero-filling the low positions
  assign leftSlot  = CH_SLOTS'(leftIn)    << PAD_W;
  assign rightSlot = CH_SLOTS'(rightHold) << PAD_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rightHold <= '0;
      shiftReg  <= '0;
    end else if (strobes.loadPair) begin
      rightHold <= rightIn;
      shiftReg  <= leftSlot;
    end else if (strobes.loadRight) begin
      shiftReg  <= rightSlot;
    end else if (strobes.shift) begin
      shiftReg  <= shiftReg << 1;
    end
  end

  assign sdOut = shiftReg[CH_SLOTS-1];

  p_right_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPair |=> (rightHold == $past(rightIn)));
  p_right_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadPair |=> $stable(rightHold));
  p_sd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadPair || strobes.loadRight || strobes.shift) |=> $stable(sdOut));

  generate
    if (PAD_W > 0) begin : g_pad_check
      p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.loadPair || strobes.loadRight) |=> (shiftReg[PAD_W-1:0] == '0));
    end
  endgenerate
endmodule

// File: rtl/i2s_stereo_serializer.sv
`timescale 1ns/1ps
module i2s_stereo_serializer
  import i2s_ser_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter bit INV_BCLK = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClkIn,
  input  logic                bitStrobe,
  input  logic                frameRestart,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                sclkOut,
  output logic                wsOut,
  output logic                sdOut,
  output logic                sampleTaken
);
  ctrlStrobe_t strobes;

  generate
    if (SAMPLE_W < 8 || SAMPLE_W > CH_SLOTS) begin : g_bad_width
      $error("SAMPLE_W must lie in 8..32");
    end
    if (INV_BCLK) begin : g_bclk_inv
      assign sclkOut = ~bitClkIn;
    end else begin : g_bclk_direct
      assign sclkOut = bitClkIn;
    end
  endgenerate

  i2s_ser_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .bitStrobe    (bitStrobe),
    .frameRestart (frameRestart),
    .strobes      (strobes),
    .wsOut        (wsOut),
    .sampleTaken  (sampleTaken)
  );

  i2s_ser_datapath #(.SAMPLE_W(SAMPLE_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .leftIn  (leftIn),
    .rightIn (rightIn),
    .sdOut   (sdOut)
  );

  p_sclk_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut == (bitClkIn ^ INV_BCLK));
endmodule

// File: tb/tb_i2s_stereo_serializer.sv
`timescale 1ns/1ps
module tb_i2s_stereo_serializer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        bitStrobe = 1'b0;
  logic        frameRestart = 1'b0;
  logic [15:0] leftW = '0;
  logic [15:0] rightW = '0;
  logic        sclkW, wsW, sdW, takenW;
  logic        sclkN, wsN, sdN, takenN;

  i2s_stereo_serializer #(.SAMPLE_W(16), .INV_BCLK(1'b0)) dut (
    .clk(clk), .rstN(rstN), .bitClkIn(bitClk), .bitStrobe(bitStrobe),
    .frameRestart(frameRestart), .leftIn(leftW), .rightIn(rightW),
    .sclkOut(sclkW), .wsOut(wsW), .sdOut(sdW), .sampleTaken(takenW));

  i2s_stereo_serializer #(.SAMPLE_W(8), .INV_BCLK(1'b1)) dutNarrow (
    .clk(clk), .rstN(rstN), .bitClkIn(bitClk), .bitStrobe(bitStrobe),
    .frameRestart(frameRestart), .leftIn(leftW[15:8]), .rightIn(rightW[15:8]),
    .sclkOut(sclkN), .wsOut(wsN), .sdOut(sdN), .sampleTaken(takenN));

  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  int  stableErr, sclkErr;
  logic curSd, curSdN, curWs, curWsN, curTaken, curTakenN;

  // L16,R16 pairs
  localparam logic [31:0] VEC [6] = '{
    32'h8000_7FFF, 32'hAAAA_5555, 32'h0001_FFFF,
    32'hFFFF_0000, 32'h1234_FEDC, 32'h00FF_FF00 };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic look();
    if (sdW !== curSd || sdN !== curSdN || wsW !== curWs || wsN !== curWsN ||
        takenW !== curTaken || takenN !== curTakenN) stableErr++;
    if (sclkW !== bitClk || sclkN !== ~bitClk) sclkErr++;
  endtask

  task automatic slot(input bit restart);
    @(negedge clk); bitStrobe = 1'b1; frameRestart = restart; bitClk = 1'b0;
    @(negedge clk); bitStrobe = 1'b0; frameRestart = 1'b0;
    curSd = sdW; curSdN = sdN; curWs = wsW; curWsN = wsN;
    curTaken = takenW; curTakenN = takenN;
    look();
    bitClk = 1'b1;
    @(negedge clk); look();
    @(negedge clk); look();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); look();
    end
  endtask

  task automatic frame(input logic [15:0] l, input logic [15:0] r, input int pauseAt);
    logic [31:0] gotL, gotR, gotLN, gotRN;
    int wsErr, takenErr;
    gotL = '0; gotR = '0; gotLN = '0; gotRN = '0;
    wsErr = 0; takenErr = 0; stableErr = 0; sclkErr = 0;
    leftW = l; rightW = r;
    for (int k = 0; k < 64; k++) begin
      slot(1'b0);
      if (k < 32) begin
        gotL = {gotL[30:0], curSd}; gotLN = {gotLN[30:0], curSdN};
      end else begin
        gotR = {gotR[30:0], curSd}; gotRN = {gotRN[30:0], curSdN};
      end
      if (curWs !== (k >= 31 && k <= 62) || curWsN !== curWs) wsErr++;
      if (curTaken !== (k == 62) || curTakenN !== curTaken) takenErr++;
      if (k == 0) begin leftW = ~l; rightW = ~r; end  // R3: late change ignored
      if (k == pauseAt) idle(13);                        // R2: no strobes
    end
    check(gotL == {l, 16'h0}, "R4", "left slot", gotL, {l, 16'h0});
    check(gotR == {r, 16'h0}, "R3", "right slot after late input change", gotR, {r, 16'h0});
    check(gotLN == {l[15:8], 24'h0}, "R5", "narrow left slot", gotLN, {l[15:8], 24'h0});
    check(gotRN == {r[15:8], 24'h0}, "R5", "narrow right slot", gotRN, {r[15:8], 24'h0});
    check(wsErr == 0, "R6", "word select mismatches", wsErr, 0);
    check(takenErr == 0, "R7", "capture marker mismatches", takenErr, 0);
    check(stableErr == 0, "R8", "outputs moved within a period", stableErr, 0);
    check(sclkErr == 0, "R10", "bit clock polarity mismatches", sclkErr, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check({sdW, wsW, takenW, sdN, wsN, takenN} == 6'b0, "R1", "outputs in reset",
          {sdW, wsW, takenW, sdN, wsN, takenN}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check({sdW, wsW, takenW} == 3'b0, "R1", "outputs after release", {sdW, wsW, takenW}, 0);

    // table-driven frames; the third one pauses mid-frame (R2)
    for (int i = 0; i < 6; i++)
      frame(VEC[i][31:16], VEC[i][15:0], (i == 2) ? 10 : -1);

    // R9: resync in the middle of a frame
    leftW = 16'h5A5A; rightW = 16'hA5A5;
    for (int i = 0; i < 20; i++) slot(1'b0);
    slot(1'b1);
    check(curTaken == 1'b0 && curWs == 1'b0, "R9", "marker/ws after resync strobe",
          {curTaken, curWs}, 0);
    frame(16'hC3A1, 16'h1E2D, -1);
    check(nFail == 0, "R9", "frame aligned after resync", nFail, 0);

    // R1: reset in the middle of a frame restarts the frame
    for (int i = 0; i < 40; i++) slot(1'b0);
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    check({sdW, wsW, takenW} == 3'b0, "R1", "outputs in mid-frame reset", {sdW, wsW, takenW}, 0);
    rstN = 1'b1;
    frame(16'h7001, 16'h8FFE, -1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule